// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Arbiter

This block sits between a group of peripheral interrupt sources and a processor core. Each source has a flag, an enable and a one-bit control level. There is also a single non-maskable input. Every cycle the arbiter looks at the requests that are enabled and raised. It takes the core's two mask bits into account and chooses at most one candidate. Level-1 sources form a higher tier. They can still reach the core when only the first mask bit is set. The non-maskable input outranks everything and ignores both mask bits.

A candidate is accepted only in a cycle where the core reports that an instruction has completed. On acceptance, three registered outputs change on the next clock edge. A one-cycle accept strobe goes high. A one-cycle request to set both mask bits goes high. The vector output is loaded with the handler number of the winner. A maskable source that is not accepted keeps its flag, so it stays pending until it wins or is withdrawn. The non-maskable input is caught on its rising edge and latched until it is accepted.

Top module: `irq_two_level_arb`

## Requirements
- R1: While `rst_n` is low, `accept` and `set_masks` are 0 and `vector` is 0.
- R2: Source k requests service only when both `src_flag[k]` and `src_en[k]` are 1. A flag without its enable, or an enable without its flag, never produces an acceptance.
- R3: When any enabled level-1 request (`icr[k]`=1) may be taken, it wins over every level-0 request (`icr[k]`=0).
- R4: Among competing requests of the same level, the lowest source index wins.
- R5: A level-0 request is accepted only when `i_bit` is 0.
- R6: A level-1 request is accepted when `i_bit` is 0, or when `i_bit` is 1 and `ui_bit` is 0.
- R7: With `i_bit` and `ui_bit` both 1, only the non-maskable request can be accepted.
- R8: Acceptance happens only on a clock edge where `insn_done` is 1. The outputs reflect it one cycle later, and without `insn_done` nothing is accepted.
- R9: On acceptance, `accept` and `set_masks` are both 1 for exactly that one cycle. `vector` becomes VEC_BASE + k for source k, or NMI_VEC for the non-maskable request. `vector` holds its last value otherwise.
- R10: A rising edge on `nmi` is latched one cycle after it is seen. While latched, the non-maskable request wins over all maskable requests, whatever the mask bits hold.
- R11: The non-maskable latch clears when it is accepted. Holding `nmi` high does not raise a second request until `nmi` falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_flag | input | N | Raised source flags |
| src_en | input | N | Per-source enables |
| icr | input | N | Per-source control level (1 = upper tier) |
| nmi | input | 1 | Non-maskable request, edge-sensitive |
| i_bit | input | 1 | Primary mask bit from the core |
| ui_bit | input | 1 | Secondary mask bit from the core |
| insn_done | input | 1 | Core reports an instruction boundary |
| accept | output | 1 | One-cycle acceptance strobe |
| vector | output | 8 | Vector number of the accepted request |
| set_masks | output | 1 | One-cycle request to set both mask bits |

## Verification
The bench targets these corner cases:
- Mask pattern i=1, ui=0, with level-0 and level-1 sources pending together. A design that treated `ui_bit` as a plain second mask would block the level-1 source. A design that ignored `i_bit` for level 0 would let the level-0 source through.
- Several same-level sources pending at once. This exposes a reversed or rotating priority order.
- A non-maskable edge that arrives with both masks set, or while `insn_done` is low. A missing latch would lose the request. A level-sensitive latch would re-fire while `nmi` stays high after acceptance.
- Sources with only their flag or only their enable set. Any acceptance there shows a missing gate.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int VEC_W = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_NMI  = 2'd1,
        SEL_LVL1 = 2'd2,
        SEL_LVL0 = 2'd3
    } sel_kind_e;

    typedef struct packed {
        logic             accept;
        logic             set_masks;
        logic [VEC_W-1:0] vector;
        logic             nmi_prev;
        logic             nmi_pend;
    } arb_state_t;

endpackage

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
    parameter int N = 16
) (
    input  logic [N-1:0] src_flag,
    input  logic [N-1:0] src_en,
    input  logic [N-1:0] icr,
    output logic [N-1:0] lvl1_req,
    output logic [N-1:0] lvl0_req
);

    // Per-source gating: a source asks only when flagged and enabled,
    // then splits onto one of the two tiers by its control level.
    for (genvar g = 0; g < N; g++) begin : g_src
        logic live;
        assign live        = src_flag[g] & src_en[g];
        assign lvl1_req[g] = live &  icr[g];
        assign lvl0_req[g] = live & ~icr[g];
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);

    // Fixed order: the scan runs downward so the lowest set index
    // is the last one written and therefore wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                hit = 1'b1;
                idx = IW'(k);
            end
        end
    end

endmodule

// File: rtl/irq_level_select.sv
module irq_level_select
    import irq_arb_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic          nmi_pend,
    input  logic          hit1,
    input  logic [IW-1:0] idx1,
    input  logic          hit0,
    input  logic [IW-1:0] idx0,
    input  logic          i_bit,
    input  logic          ui_bit,
    output sel_kind_e     kind,
    output logic [IW-1:0] idx
);

    logic lvl1_open;
    logic lvl0_open;

    // Upper tier passes unless both masks are set; lower tier needs I clear.
    assign lvl1_open = ~i_bit | ~ui_bit;
    assign lvl0_open = ~i_bit;

    always_comb begin
        kind = SEL_NONE;
        idx  = '0;
        if (nmi_pend) begin
            kind = SEL_NMI;
        end else if (hit1 && lvl1_open) begin
            kind = SEL_LVL1;
            idx  = idx1;
        end else if (hit0 && lvl0_open) begin
            kind = SEL_LVL0;
            idx  = idx0;
        end
    end

endmodule

// File: rtl/irq_two_level_arb.sv
module irq_two_level_arb
    import irq_arb_pkg::*;
#(
    parameter int                N        = 16,
    parameter logic [VEC_W-1:0]  VEC_BASE = 8'd64,
    parameter logic [VEC_W-1:0]  NMI_VEC  = 8'd7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     src_flag,
    input  logic [N-1:0]     src_en,
    input  logic [N-1:0]     icr,
    input  logic             nmi,
    input  logic             i_bit,
    input  logic             ui_bit,
    input  logic             insn_done,
    output logic             accept,
    output logic [VEC_W-1:0] vector,
    output logic             set_masks
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]  lvl1_req;
    logic [N-1:0]  lvl0_req;
    logic          hit1;
    logic          hit0;
    logic [IW-1:0] idx1;
    logic [IW-1:0] idx0;
    logic [IW-1:0] win_idx;
    sel_kind_e     win_kind;
    arb_state_t    st_d;
    arb_state_t    st_q;
    logic          take;
    logic          nmi_edge;

    irq_req_gate #(.N(N)) u_gate (
        .src_flag (src_flag),
        .src_en   (src_en),
        .icr      (icr),
        .lvl1_req (lvl1_req),
        .lvl0_req (lvl0_req)
    );

    irq_prio_pick #(.N(N), .IW(IW)) u_pick1 (
        .req (lvl1_req),
        .hit (hit1),
        .idx (idx1)
    );

    irq_prio_pick #(.N(N), .IW(IW)) u_pick0 (
        .req (lvl0_req),
        .hit (hit0),
        .idx (idx0)
    );

    irq_level_select #(.IW(IW)) u_sel (
        .nmi_pend (st_q.nmi_pend),
        .hit1     (hit1),
        .idx1     (idx1),
        .hit0     (hit0),
        .idx0     (idx0),
        .i_bit    (i_bit),
        .ui_bit   (ui_bit),
        .kind     (win_kind),
        .idx      (win_idx)
    );

    always_comb begin
        st_d           = st_q;
        st_d.accept    = 1'b0;
        st_d.set_masks = 1'b0;
        take           = insn_done && (win_kind != SEL_NONE);
        nmi_edge       = nmi & ~st_q.nmi_prev;
        if (take) begin
            st_d.accept    = 1'b1;
            st_d.set_masks = 1'b1;
            if (win_kind == SEL_NMI) begin
                st_d.vector = NMI_VEC;
            end else begin
                st_d.vector = VEC_BASE + VEC_W'(win_idx);
            end
        end
        st_d.nmi_prev = nmi;
        st_d.nmi_pend = (st_q.nmi_pend & ~(take && win_kind == SEL_NMI)) | nmi_edge;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept    = st_q.accept;
    assign set_masks = st_q.set_masks;
    assign vector    = st_q.vector;

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
    parameter int          N        = 16,
    parameter logic [7:0]  VEC_BASE = 8'd64,
    parameter logic [7:0]  NMI_VEC  = 8'd7
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] src_flag,
    input logic [N-1:0] src_en,
    input logic [N-1:0] icr,
    input logic         nmi,
    input logic         i_bit,
    input logic         ui_bit,
    input logic         insn_done,
    input logic         accept,
    input logic [7:0]   vector,
    input logic         set_masks
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0] prev_req_q;
    logic [N-1:0] prev_icr_q;
    logic         prev_i_q;
    logic         prev_ui_q;
    logic         prev_done_q;
    logic [7:0]   off;
    logic [IW-1:0] sidx;
    logic         in_range;
    logic         is_nmi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_req_q  <= '0;
            prev_icr_q  <= '0;
            prev_i_q    <= 1'b0;
            prev_ui_q   <= 1'b0;
            prev_done_q <= 1'b0;
        end else begin
            prev_req_q  <= src_flag & src_en;
            prev_icr_q  <= icr;
            prev_i_q    <= i_bit;
            prev_ui_q   <= ui_bit;
            prev_done_q <= insn_done;
        end
    end

    assign off      = vector - VEC_BASE;
    assign in_range = (off < 8'(N));
    assign sidx     = off[IW-1:0];
    assign is_nmi   = (vector == NMI_VEC);

    assert_boundary_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> prev_done_q);

    assert_strobes_paired_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept == set_masks);

    assert_strobe_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept || $past(insn_done));

    assert_gated_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_nmi) |-> (in_range && prev_req_q[sidx]));

    assert_full_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && prev_i_q && prev_ui_q) |-> is_nmi);

    assert_partial_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && prev_i_q && !is_nmi) |-> (prev_icr_q[sidx] && !prev_ui_q));

    assert_held_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && $past(rst_n)) |-> $stable(vector));

endmodule

bind irq_two_level_arb irq_arb_chk #(
    .N        (N),
    .VEC_BASE (VEC_BASE),
    .NMI_VEC  (NMI_VEC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_flag  (src_flag),
    .src_en    (src_en),
    .icr       (icr),
    .nmi       (nmi),
    .i_bit     (i_bit),
    .ui_bit    (ui_bit),
    .insn_done (insn_done),
    .accept    (accept),
    .vector    (vector),
    .set_masks (set_masks)
);

// File: tb/sim_irq_two_level_arb.sv
module sim_irq_two_level_arb;

    localparam int         N        = 16;
    localparam logic [7:0] VEC_BASE = 8'd64;
    localparam logic [7:0] NMI_VEC  = 8'd7;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] src_flag;
    logic [N-1:0] src_en;
    logic [N-1:0] icr;
    logic         nmi;
    logic         i_bit;
    logic         ui_bit;
    logic         insn_done;
    logic         accept;
    logic [7:0]   vector;
    logic         set_masks;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic       m_prev;
    logic       m_pend;
    logic [7:0] m_vec;

    always #10 clk = ~clk;

    irq_two_level_arb #(.N(N), .VEC_BASE(VEC_BASE), .NMI_VEC(NMI_VEC)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_flag  (src_flag),
        .src_en    (src_en),
        .icr       (icr),
        .nmi       (nmi),
        .i_bit     (i_bit),
        .ui_bit    (ui_bit),
        .insn_done (insn_done),
        .accept    (accept),
        .vector    (vector),
        .set_masks (set_masks)
    );

    // returns -2 for none, -1 for the non-maskable request, else source index
    function automatic int pick_winner(logic [N-1:0] f, logic [N-1:0] e, logic [N-1:0] c,
                                       logic i, logic ui, logic pend);
        int up = -2;
        int lo = -2;
        if (pend) return -1;
        for (int j = 0; j < N; j++) begin
            if (f[j] && e[j]) begin
                if (c[j] && up == -2) up = j;
                if (!c[j] && lo == -2) lo = j;
            end
        end
        if (up >= 0 && !(i && ui)) return up;
        if (lo >= 0 && !i) return lo;
        return -2;
    endfunction

    task automatic report(string tag, logic ok, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    task automatic step(string tag);
        int   w;
        logic x_acc;
        w     = pick_winner(src_flag, src_en, icr, i_bit, ui_bit, m_pend);
        x_acc = insn_done && (w != -2);
        if (x_acc) m_vec = (w == -1) ? NMI_VEC : VEC_BASE + 8'(w);
        m_pend = (m_pend && !(x_acc && w == -1)) || (nmi && !m_prev);
        m_prev = nmi;
        @(posedge clk);
        @(negedge clk);
        report(tag, accept == x_acc && set_masks == x_acc && vector == m_vec,
               $sformatf("acc=%0b sm=%0b vec=%0d expected acc=%0b sm=%0b vec=%0d",
                         accept, set_masks, vector, x_acc, x_acc, m_vec));
    endtask

    task automatic quiet();
        src_flag  = '0;
        src_en    = '0;
        icr       = '0;
        nmi       = 1'b0;
        i_bit     = 1'b0;
        ui_bit    = 1'b0;
        insn_done = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        quiet();
        rst_n  = 1'b0;
        m_prev = 1'b0;
        m_pend = 1'b0;
        m_vec  = 8'd0;
        src_flag = '1; src_en = '1; insn_done = 1'b1; nmi = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet under reset despite busy inputs
        report("R1", accept == 1'b0 && set_masks == 1'b0 && vector == 8'd0,
               $sformatf("acc=%0b sm=%0b vec=%0d expected 0 0 0", accept, set_masks, vector));
        quiet();
        rst_n = 1'b1;
        step("R1");

        // R2: flag without enable, enable without flag
        src_flag = 16'hFFFF; src_en = 16'h0000; insn_done = 1'b1;
        step("R2");
        src_flag = 16'h0000; src_en = 16'hFFFF;
        step("R2");
        src_flag = 16'h0F0F; src_en = 16'h0F00;
        step("R2");

        // R4: same level, lowest index wins
        quiet(); insn_done = 1'b1;
        src_flag = 16'b1010_0000_0000_1010; src_en = '1;
        step("R4");
        icr = '1;
        step("R4");

        // R3: level-1 source beats a lower-index level-0 source
        icr = '0; icr[13] = 1'b1;
        step("R3");

        // R5: level-0 only, I set -> held; then I clear -> taken
        quiet(); src_flag = 16'h0011; src_en = '1; insn_done = 1'b1;
        i_bit = 1'b1; ui_bit = 1'b0;
        step("R5");
        i_bit = 1'b0;
        step("R5");

        // R6: I set, UI clear -> level-1 gets through, level-0 does not
        i_bit = 1'b1; ui_bit = 1'b0; icr[4] = 1'b1;
        step("R6");
        i_bit = 1'b0; ui_bit = 1'b1;
        step("R6");

        // R7: both masks set -> nothing maskable
        i_bit = 1'b1; ui_bit = 1'b1; icr = '1;
        step("R7");

        // R8: no boundary, no acceptance
        i_bit = 1'b0; ui_bit = 1'b0; insn_done = 1'b0;
        step("R8");
        step("R8");

        // R10: edge while busy and masked, latched across no-boundary cycles
        i_bit = 1'b1; ui_bit = 1'b1; nmi = 1'b1;
        step("R10");
        step("R10");
        insn_done = 1'b1;
        step("R10");
        // R11: nmi held high, must not re-fire
        step("R11");
        step("R11");
        nmi = 1'b0;
        step("R11");
        // R10: non-maskable beats level-1 with masks open
        i_bit = 1'b0; ui_bit = 1'b0; nmi = 1'b1;
        step("R10");
        step("R10");
        nmi = 1'b0;
        step("R9");
        insn_done = 1'b0;
        step("R9");

        // random phase, biased toward sparse requests
        for (int n = 0; n < 4000; n++) begin
            src_flag  = 16'($urandom) & 16'($urandom);
            src_en    = 16'($urandom) | 16'($urandom);
            icr       = 16'($urandom);
            i_bit     = 1'($urandom);
            ui_bit    = 1'($urandom);
            insn_done = ($urandom % 3) != 0;
            if (($urandom % 16) == 0) nmi = ~nmi;
            step("R8");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule